// File: doc/BRIEF.md
# Real-Time Clock Alarm, Timer and Interrupt Controller

This block watches the time-of-day counter bytes of a real-time clock and decides when an alarm has happened. A clock alarm can compare time only (daily), time plus a weekday bitmask (weekday), or time plus date and month (dated). Beside the comparison it keeps a two-digit BCD timer. The timer steps at a chosen unit: hundredths, seconds, minutes, hours or days. A timer wrap and a timer match each have their own effect. The results are two sticky flags: an alarm flag and a timer flag. Software clears them with a write. An active-low interrupt output follows the flags through two enable bits.

When the alarm-enable input is low, the alarm control byte has no effect. The two flag outputs then become 50% duty squares, one per second and one per minute. The interrupt output becomes a 1 Hz square wave that is high in the first half of each second. The counter bytes and the unit strobes come from the surrounding clock/calendar. The alarm bytes and the control bytes come from its register file.

Top module: `rtc_alarm_ctrl`

## Requirements
- R1: After reset the timer reads 8'h00, both stored flags are 0 and int_n is high while the hundredths byte is below 8'h50.
- R2: The timer counts in BCD from 00 to 99 and then returns to 00. The advance out of 99 raises tmr_set for that cycle and sets the timer flag on the following edge.
- R3: Timer resolution comes from actl[2:0]. The codes 1 to 5 step the timer on unit_stb bit 0 (hundredths), 1 (seconds), 2 (minutes), 3 (hours) or 4 (days). The codes 0, 6 and 7 hold the timer.
- R4: actl[5:4]=01 selects the daily alarm. alm_set pulses in any cycle with unit_stb[0] high in which the hundredths, seconds, minutes and hours bytes all equal their alarm bytes. Date and month play no part.
- R5: actl[5:4]=10 selects the weekday alarm. It is the daily match, additionally gated by alm_wkmon[wd], where wd is cnt_wkmon[7:5]. A weekday of 7 never matches.
- R6: actl[5:4]=11 selects the dated alarm. It is the daily match plus cnt_date[5:0]==alm_date[5:0] and cnt_wkmon[4:0]==alm_wkmon[4:0], so the year bits 7:6 and the weekday bits 7:5 are ignored. actl[5:4]=00 gives no clock alarm.
- R7: With actl[6]=1, a timer advance whose new value equals alm_tmr raises alm_set.
- R8: With alarms enabled, int_n is low exactly when (alarm flag and actl[7]) or (timer flag and actl[3]).
- R9: Each flag holds until a flag_wr cycle loads it from flag_wdata: bit 1 goes to the alarm flag and bit 0 to the timer flag. A set event in the same cycle as such a write wins.
- R10: With alm_en=0, no set strobes occur and the stored flags are held at 0. tmr_flag reads cnt_hs>=8'h50, alm_flag reads cnt_sec>=8'h30, int_n reads cnt_hs<8'h50, and the timer steps on the days strobe.
- R11: The hours byte is compared on all 8 bits, so a difference in the 12 h format bit 7 or in the PM bit 6 prevents a match.
- R12: A tmr_we cycle loads tmr_wdata into the timer and suppresses that cycle's advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alm_en | input | 1 | Alarm-enable bit of the control/status byte |
| actl | input | 8 | Alarm control byte |
| unit_stb | input | 5 | Unit advance strobes: hundredths, seconds, minutes, hours, days |
| cnt_hs | input | 8 | Hundredths counter, BCD |
| cnt_sec | input | 8 | Seconds counter, BCD |
| cnt_min | input | 8 | Minutes counter, BCD |
| cnt_hr | input | 8 | Hours counter, including format and PM bits |
| cnt_date | input | 8 | Year (7:6) and date (5:0) |
| cnt_wkmon | input | 8 | Weekday (7:5) and month (4:0) |
| alm_hs | input | 8 | Alarm hundredths |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hr | input | 8 | Alarm hours |
| alm_date | input | 8 | Alarm date |
| alm_wkmon | input | 8 | Alarm month, or weekday mask in weekday mode |
| alm_tmr | input | 8 | Alarm timer value |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write value |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write values: bit 1 alarm, bit 0 timer |
| alm_set | output | 1 | Alarm flag set strobe |
| tmr_set | output | 1 | Timer flag set strobe |
| alm_flag | output | 1 | Alarm flag as read back |
| tmr_flag | output | 1 | Timer flag as read back |
| timer | output | 8 | Timer value, BCD |
| int_n | output | 1 | Interrupt, active low, open-drain level |

## Verification
Two cases can land in the same cycle. The first is a software flag write and a set event: a timer wrap out of 99, or a clock or timer alarm match. The second is a timer write and a timer advance. The bench provokes the first directly. It loads 99, then pulses the selected unit strobe together with a write of 0 to the flags, and it expects the flag to read 1 afterwards. The random phase also issues flag writes and timer writes at rates that often coincide with strobes. A bench model applies "set wins" and "write beats advance" to judge every cycle.

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alm_en,
  input  logic [7:0] actl,
  input  logic [4:0] unit_stb,
  input  logic [7:0] cnt_hs,
  input  logic [7:0] cnt_sec,
  input  logic [7:0] cnt_min,
  input  logic [7:0] cnt_hr,
  input  logic [7:0] cnt_date,
  input  logic [7:0] cnt_wkmon,
  input  logic [7:0] alm_hs,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hr,
  input  logic [7:0] alm_date,
  input  logic [7:0] alm_wkmon,
  input  logic [7:0] alm_tmr,
  input  logic       tmr_we,
  input  logic [7:0] tmr_wdata,
  input  logic       flag_wr,
  input  logic [1:0] flag_wdata,
  output logic       alm_set,
  output logic       tmr_set,
  output logic       alm_flag,
  output logic       tmr_flag,
  output logic [7:0] timer,
  output logic       int_n
);
  logic [7:0] tmr_q;
  logic       af_q, tf_q;
  logic       tsel, mode_ok;

  always_comb begin
    case (actl[2:0])
      3'd1:    tsel = unit_stb[0];
      3'd2:    tsel = unit_stb[1];
      3'd3:    tsel = unit_stb[2];
      3'd4:    tsel = unit_stb[3];
      3'd5:    tsel = unit_stb[4];
      default: tsel = 1'b0;
    endcase
  end

  wire       tmr_adv  = !tmr_we && (alm_en ? tsel : unit_stb[4]);
  wire       tmr_wrap = (tmr_q == 8'h99);
  wire [7:0] tmr_inc  = tmr_wrap ? 8'h00 :
                        (tmr_q[3:0] == 4'd9) ? {tmr_q[7:4] + 4'd1, 4'd0} :
                        {tmr_q[7:4], tmr_q[3:0] + 4'd1};

  wire       time_eq = (cnt_hs == alm_hs) && (cnt_sec == alm_sec) &&
                       (cnt_min == alm_min) && (cnt_hr == alm_hr);
  wire [2:0] wday    = cnt_wkmon[7:5];
  wire       wday_ok = (wday != 3'd7) && alm_wkmon[wday];
  wire       date_eq = (cnt_date[5:0] == alm_date[5:0]) &&
                       (cnt_wkmon[4:0] == alm_wkmon[4:0]);

  always_comb begin
    case (actl[5:4])
      2'b01:   mode_ok = 1'b1;
      2'b10:   mode_ok = wday_ok;
      2'b11:   mode_ok = date_eq;
      default: mode_ok = 1'b0;
    endcase
  end

  assign alm_set = alm_en && ((unit_stb[0] && time_eq && mode_ok) ||
                              (tmr_adv && actl[6] && (tmr_inc == alm_tmr)));
  assign tmr_set = alm_en && tmr_adv && tmr_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= 8'h00;
      af_q  <= 1'b0;
      tf_q  <= 1'b0;
    end else begin
      if (tmr_we)       tmr_q <= tmr_wdata;
      else if (tmr_adv) tmr_q <= tmr_inc;
      af_q <= alm_en && (alm_set || (flag_wr ? flag_wdata[1] : af_q));
      tf_q <= alm_en && (tmr_set || (flag_wr ? flag_wdata[0] : tf_q));
    end
  end

  wire sec_sq = (cnt_hs >= 8'h50);
  wire min_sq = (cnt_sec >= 8'h30);

  assign timer    = tmr_q;
  assign alm_flag = alm_en ? af_q : min_sq;
  assign tmr_flag = alm_en ? tf_q : sec_sq;
  assign int_n    = alm_en ? !((af_q && actl[7]) || (tf_q && actl[3])) : !sec_sq;
endmodule

// File: rtl/rtc_alarm_ctrl_chk.sv
module rtc_alarm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alm_en,
  input logic [7:0] actl,
  input logic [4:0] unit_stb,
  input logic [7:0] alm_tmr,
  input logic       flag_wr,
  input logic       alm_set,
  input logic       tmr_set,
  input logic       alm_flag,
  input logic       tmr_flag,
  input logic [7:0] timer,
  input logic       int_n
);
  p_int_alarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alm_en && alm_flag && actl[7] |-> !int_n);
  p_int_timer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alm_en && tmr_flag && actl[3] |-> !int_n);
  p_int_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alm_en && !alm_flag && !tmr_flag |-> int_n);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alm_en && alm_set |=> (!alm_en || alm_flag));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alm_en && alm_flag && !flag_wr |=> (!alm_en || alm_flag));
  p_wrap_from_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_set |-> timer == 8'h99);
  p_wrap_to_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_set |=> timer == 8'h00);
  p_tick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alm_set && !actl[6] |-> unit_stb[0]);
  p_tmr_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alm_set && !unit_stb[0] |=> timer == $past(alm_tmr));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_en |-> !alm_set && !tmr_set);
endmodule

bind rtc_alarm_ctrl rtc_alarm_ctrl_chk u_chk (.*);

// File: tb/rtc_alarm_ctrl_test.sv
module rtc_alarm_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic alm_en = 0, tmr_we = 0, flag_wr = 0;
  logic [7:0] actl = 0, cnt_hs = 0, cnt_sec = 0, cnt_min = 0, cnt_hr = 0;
  logic [7:0] cnt_date = 8'h01, cnt_wkmon = 8'h01;
  logic [7:0] alm_hs = 0, alm_sec = 0, alm_min = 0, alm_hr = 0, alm_date = 0, alm_wkmon = 0, alm_tmr = 0;
  logic [7:0] tmr_wdata = 0;
  logic [4:0] unit_stb = 0;
  logic [1:0] flag_wdata = 0;
  logic alm_set, tmr_set, alm_flag, tmr_flag, int_n;
  logic [7:0] timer;

  int checks = 0, failures = 0;
  logic [7:0] m_tmr = 0;
  bit m_af = 0, m_tf = 0;

  rtc_alarm_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v == 8'h99) return 8'h00;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bit clk_match();
    bit t = cnt_hs == alm_hs && cnt_sec == alm_sec && cnt_min == alm_min && cnt_hr == alm_hr;
    case (actl[5:4])
      2'b01: return t;
      2'b10: return t && cnt_wkmon[7:5] != 3'd7 && alm_wkmon[cnt_wkmon[7:5]];
      2'b11: return t && cnt_date[5:0] == alm_date[5:0] && cnt_wkmon[4:0] == alm_wkmon[4:0];
      default: return 0;
    endcase
  endfunction

  function automatic string mode_tag();
    case (actl[5:4])
      2'b01: return "R4 daily";
      2'b10: return "R5 weekday";
      2'b11: return "R6 dated";
      default: return "R7 timer alarm";
    endcase
  endfunction

  // inputs are set before calling; checks strobes, then state after the edge
  task automatic step();
    bit sel, adv, ea, et;
    logic [7:0] nx;
    sel = (actl[2:0] >= 3'd1 && actl[2:0] <= 3'd5) ? unit_stb[actl[2:0] - 3'd1] : 1'b0;
    adv = !tmr_we && (alm_en ? sel : unit_stb[4]);
    nx  = bcd_inc(m_tmr);
    ea  = alm_en && ((unit_stb[0] && clk_match()) || (adv && actl[6] && nx == alm_tmr));
    et  = alm_en && adv && m_tmr == 8'h99;
    #2;
    check(alm_set == ea, mode_tag(), {7'd0, alm_set}, {7'd0, ea});
    check(tmr_set == et, "R2 wrap strobe", {7'd0, tmr_set}, {7'd0, et});
    if (tmr_we) m_tmr = tmr_wdata; else if (adv) m_tmr = nx;
    m_af = alm_en && (ea || (flag_wr ? flag_wdata[1] : m_af));
    m_tf = alm_en && (et || (flag_wr ? flag_wdata[0] : m_tf));
    @(posedge clk); #1;
    check(timer == m_tmr, tmr_we ? "R12 timer load" : "R3 timer step", timer, m_tmr);
    if (alm_en) begin
      check(alm_flag == m_af && tmr_flag == m_tf, "R9 flags", {6'd0, alm_flag, tmr_flag}, {6'd0, m_af, m_tf});
      check(int_n == !((m_af && actl[7]) || (m_tf && actl[3])), "R8 interrupt",
            {7'd0, int_n}, {7'd0, !((m_af && actl[7]) || (m_tf && actl[3]))});
    end else begin
      check(tmr_flag == (cnt_hs >= 8'h50) && alm_flag == (cnt_sec >= 8'h30) && int_n == (cnt_hs < 8'h50),
            "R10 squares", {5'd0, alm_flag, tmr_flag, int_n},
            {5'd0, cnt_sec >= 8'h30, cnt_hs >= 8'h50, cnt_hs < 8'h50});
    end
    unit_stb = 0; tmr_we = 0; flag_wr = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    check(timer == 8'h00, "R1 timer", timer, 8'h00);
    check(int_n == 1'b1, "R1 int_n", {7'd0, int_n}, 8'd1);
    alm_en = 1; #1;
    check(!alm_flag && !tmr_flag, "R1 flags", {6'd0, alm_flag, tmr_flag}, 8'd0);

    // R3 seconds resolution ignores hundredths strobe
    actl = 8'h0A;
    unit_stb = 5'b00001; step();
    check(timer == 8'h00, "R3 wrong unit", timer, 8'h00);
    unit_stb = 5'b00010; step();
    check(timer == 8'h01, "R3 seconds step", timer, 8'h01);
    // R12 write beats advance, R2 wrap, R9 set beats clear
    tmr_we = 1; tmr_wdata = 8'h99; unit_stb = 5'b00010; step();
    check(timer == 8'h99, "R12 load", timer, 8'h99);
    unit_stb = 5'b00010; flag_wr = 1; flag_wdata = 2'b00; step();
    check(timer == 8'h00 && tmr_flag, "R2 wrap sets flag", {timer[6:0], tmr_flag}, 8'h01);
    check(!int_n, "R8 timer interrupt", {7'd0, int_n}, 8'd0);
    flag_wr = 1; flag_wdata = 2'b00; step();
    check(!tmr_flag && int_n, "R9 clear", {6'd0, tmr_flag, int_n}, 8'd1);

    // R5 weekday mask
    actl = 8'hA0; alm_hs = 8'h12; alm_sec = 8'h34; alm_min = 8'h56; alm_hr = 8'h07;
    cnt_hs = 8'h12; cnt_sec = 8'h34; cnt_min = 8'h56; cnt_hr = 8'h07;
    cnt_wkmon = {3'd3, 5'h05}; alm_wkmon = 8'b0111_0111;
    unit_stb = 5'b00001; step();
    check(!alm_flag, "R5 weekday masked", {7'd0, alm_flag}, 8'd0);
    alm_wkmon = 8'b0000_1000; unit_stb = 5'b00001; step();
    check(alm_flag && !int_n, "R5 weekday hit", {6'd0, alm_flag, int_n}, 8'd2);
    flag_wr = 1; flag_wdata = 0; step();
    // R11 12 h bits take part
    actl = 8'h90; alm_hr = 8'hC7; cnt_hr = 8'h87; unit_stb = 5'b00001; step();
    check(!alm_flag, "R11 pm bit differs", {7'd0, alm_flag}, 8'd0);
    // R6 dated ignores year/weekday
    actl = 8'hB0; alm_hr = 8'h87; cnt_date = 8'hD5; alm_date = 8'h15;
    cnt_wkmon = 8'hA9; alm_wkmon = 8'h09; unit_stb = 5'b00001; step();
    check(alm_flag, "R6 dated hit", {7'd0, alm_flag}, 8'd1);
    flag_wr = 1; flag_wdata = 0; step();
    // R7 timer alarm at minutes resolution
    actl = 8'hC3; tmr_we = 1; tmr_wdata = 8'h41; step();
    alm_tmr = 8'h42; unit_stb = 5'b00100; step();
    check(alm_flag && timer == 8'h42, "R7 timer match", timer, 8'h42);
    // R10 disabled: squares and days stepping
    alm_en = 0; cnt_hs = 8'h60; cnt_sec = 8'h31; unit_stb = 5'b10001; step();
    check(!int_n && tmr_flag && alm_flag, "R10 high half", {5'd0, alm_flag, tmr_flag, int_n}, 8'h06);
    check(timer == 8'h43, "R10 days step", timer, 8'h43);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) begin
        actl = $urandom; alm_hs = $urandom; alm_sec = $urandom; alm_min = $urandom;
        alm_hr = $urandom; alm_date = $urandom; alm_wkmon = $urandom; alm_tmr = $urandom % 8'h10 + 8'h10 * ($urandom % 10);
      end
      alm_en = ($urandom % 16) != 0;
      if ($urandom % 3 == 0) begin
        cnt_hs = alm_hs; cnt_sec = alm_sec; cnt_min = alm_min; cnt_hr = alm_hr;
      end else begin
        cnt_hs = $urandom; cnt_sec = $urandom; cnt_min = $urandom; cnt_hr = $urandom;
      end
      cnt_date  = ($urandom % 2) ? {2'($urandom), alm_date[5:0]} : 8'($urandom);
      cnt_wkmon = ($urandom % 2) ? {3'($urandom), alm_wkmon[4:0]} : 8'($urandom);
      unit_stb = 5'($urandom) & 5'($urandom);
      flag_wr = ($urandom % 8) == 0; flag_wdata = $urandom;
      tmr_we = ($urandom % 32) == 0;
      tmr_wdata = $urandom % 8'h10 + 8'h10 * ($urandom % 10);
      if (tmr_wdata[3:0] > 4'd9) tmr_wdata[3:0] = 4'd9;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule